// File: doc/BRIEF.md
# Output-Stationary Systolic Matrix Multiplier

The block computes one N×N tile of the product C = A×B on a grid of N×N multiply-accumulate cells. Each cell keeps its running sum inside itself. Operands arrive as one column of A and one row of B per accepted beat, under a valid/ready handshake. K accepted beats make up a tile.

Inside the block, a triangular delay stage holds A lane i back by i cycles and B lane j back by j cycles. A operands then travel right through the grid one cell per cycle, and B operands travel down. As a result, A[i][k] and B[k][j] always meet in cell (i,j) on the same cycle.

After the K-th beat, the block stops accepting data. It feeds zeros into the lanes until the last product has reached the bottom-right cell, and then raises `done`. It holds the full N×N result on a parallel output until `res_ack` arrives. That acknowledge also clears every accumulator for the next tile.

Top module: `os_matmul_tile`

## Requirements
- R1: A synchronous reset, applied at any point, clears every accumulator, pipeline and skew register. After reset `c_flat` is all zero, `done` is low and `in_ready` is high.
- R2: Field layout and the sum. A beat is accepted on a rising edge where both `in_valid` and `in_ready` are high. `a_col[i*16 +: 16]` carries A[i][k] and `b_row[j*16 +: 16]` carries B[k][j] for the k-th accepted beat. Once `done` is high, `c_flat[(i*N+j)*32 +: 32]` equals the sum over k of A[i][k]·B[k][j], with every operand a signed 16-bit value.
- R3: Products and sums are formed in 32-bit two's complement and wrap on overflow, with no saturation.
- R4: While a tile is loading, `in_ready` stays high, so K beats can be accepted on K consecutive cycles.
- R5: Cycles with `in_valid` low during loading (bubbles) do not change the result.
- R6: From the edge that accepts the K-th beat until the result is acknowledged, `in_ready` is low. Data offered with `in_valid` high in that window is not consumed and does not alter the result.
- R7: With the default pipeline, `done` rises exactly 2N−1 cycles after the edge that accepted the K-th beat.
- R8: `done` stays high and `c_flat` stays unchanged until `res_ack` is sampled high.
- R9: `res_ack` sampled while `done` is high clears `done` and all accumulators on that edge, and `in_ready` is high in the next cycle. `res_ack` while `done` is low has no effect.
- R10: Each new tile starts from zero, with no residue from the previous tile.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand beat offered |
| in_ready | output | 1 | Block can take a beat this cycle |
| a_col | input | N*16 | One column of A, lane i = row i |
| b_row | input | N*16 | One row of B, lane j = column j |
| done | output | 1 | Every cell holds its final sum |
| res_ack | input | 1 | Result taken; clears the tile |
| c_flat | output | N*N*32 | Result array, cell (i,j) at index i*N+j |

## Verification
The bench drives operands at the 16-bit extremes, so that a design which saturates or truncates the 32-bit sums returns the wrong value. It inserts bubbles inside a tile, which catches a design whose lanes shift only on accepted beats and so lose alignment between A and B. It keeps `in_valid` high with junk data during the flush and while `done` is held, which exposes a design that consumes data while not ready.

The bench also counts the exact cycle on which `done` rises, so an off-by-one in the flush length is reported. It sends a stray acknowledge in the middle of a tile and resets the block in the middle of a tile. A design that clears partial sums too early, or keeps residue from a previous tile, fails on the next result.

// File: rtl/os_matmul_tile.sv
module os_matmul_tile #(
  parameter int N  = 4,
  parameter int K  = 4,
  parameter int AW = 16,
  parameter int BW = 16,
  parameter int CW = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [N*AW-1:0]   a_col,
  input  logic [N*BW-1:0]   b_row,
  output logic              done,
  input  logic              res_ack,
  output logic [N*N*CW-1:0] c_flat
);
  localparam int FL  = 2*N - 1;
  localparam int KCW = (K > 1) ? $clog2(K) : 1;
  localparam int FCW = $clog2(FL + 1);

  typedef enum logic [1:0] {S_LOAD, S_FLUSH, S_DONE} st_t;

  st_t            st;
  logic [KCW-1:0] cnt;
  logic [FCW-1:0] fcnt;
  logic           go, clr;
  logic [N*AW-1:0] a_inj, a_sk;
  logic [N*BW-1:0] b_inj, b_sk;

  logic signed [AW-1:0] a_q [N][N];
  logic signed [BW-1:0] b_q [N][N];
  logic signed [CW-1:0] acc [N][N];

  assign in_ready = (st == S_LOAD);
  assign done     = (st == S_DONE);
  assign go       = in_valid & in_ready;
  assign clr      = done & res_ack;
  assign a_inj    = go ? a_col : '0;
  assign b_inj    = go ? b_row : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= S_LOAD;
      cnt  <= '0;
      fcnt <= '0;
    end else begin
      case (st)
        S_LOAD: if (go) begin
          if (cnt == KCW'(K-1)) begin
            cnt  <= '0;
            fcnt <= '0;
            st   <= S_FLUSH;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_FLUSH: begin
          if (fcnt == FCW'(FL-1)) st <= S_DONE;
          else                    fcnt <= fcnt + 1'b1;
        end
        default: if (res_ack) st <= S_LOAD;
      endcase
    end
  end

  for (genvar l = 0; l < N; l++) begin : g_lane
    if (l == 0) begin : g_direct
      assign a_sk[AW-1:0] = a_inj[AW-1:0];
      assign b_sk[BW-1:0] = b_inj[BW-1:0];
    end else begin : g_delay
      logic [AW-1:0] sa [l];
      logic [BW-1:0] sb [l];
      always_ff @(posedge clk) begin
        if (rst) begin
          for (int d = 0; d < l; d++) begin
            sa[d] <= '0;
            sb[d] <= '0;
          end
        end else begin
          sa[0] <= a_inj[l*AW +: AW];
          sb[0] <= b_inj[l*BW +: BW];
          for (int d = 1; d < l; d++) begin
            sa[d] <= sa[d-1];
            sb[d] <= sb[d-1];
          end
        end
      end
      assign a_sk[l*AW +: AW] = sa[l-1];
      assign b_sk[l*BW +: BW] = sb[l-1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N; i++)
        for (int j = 0; j < N; j++) begin
          a_q[i][j] <= '0;
          b_q[i][j] <= '0;
          acc[i][j] <= '0;
        end
    end else begin
      for (int i = 0; i < N; i++) begin
        a_q[i][0] <= a_sk[i*AW +: AW];
        b_q[0][i] <= b_sk[i*BW +: BW];
        for (int j = 1; j < N; j++) begin
          a_q[i][j] <= a_q[i][j-1];
          b_q[j][i] <= b_q[j-1][i];
        end
      end
      for (int i = 0; i < N; i++)
        for (int j = 0; j < N; j++)
          acc[i][j] <= clr ? '0 : acc[i][j] + CW'(a_q[i][j]) * CW'(b_q[i][j]);
    end
  end

  for (genvar r = 0; r < N; r++) begin : g_out_r
    for (genvar c = 0; c < N; c++) begin : g_out_c
      assign c_flat[(r*N+c)*CW +: CW] = acc[r][c];
    end
  end
endmodule

// File: rtl/os_matmul_tile_chk.sv
module os_matmul_tile_chk #(
  parameter int N  = 4,
  parameter int K  = 4,
  parameter int CW = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              in_ready,
  input logic              done,
  input logic              res_ack,
  input logic [N*N*CW-1:0] c_flat
);
  localparam int FL  = 2*N - 1;
  localparam int SW  = $clog2(FL + 2) + 1;
  localparam int BCW = (K > 1) ? $clog2(K) : 1;

  logic [BCW-1:0] beats;
  logic [SW-1:0]  since;

  always_ff @(posedge clk) begin
    if (rst) begin
      beats <= '0;
      since <= '1;
    end else if (in_valid && in_ready) begin
      if (beats == BCW'(K-1)) begin
        beats <= '0;
        since <= '0;
      end else begin
        beats <= beats + 1'b1;
        if (since != '1) since <= since + 1'b1;
      end
    end else if (since != '1) begin
      since <= since + 1'b1;
    end
  end

  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (c_flat == '0 && !done && in_ready));

  a_r6_not_ready_when_done: assert property (@(posedge clk) disable iff (rst)
    done |-> !in_ready);

  a_r7_done_latency: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> (since == SW'(FL)));

  a_r8_done_holds: assert property (@(posedge clk) disable iff (rst)
    (done && !res_ack) |=> (done && $stable(c_flat)));

  a_r9_ack_clears: assert property (@(posedge clk) disable iff (rst)
    (done && res_ack) |=> (!done && in_ready && c_flat == '0));
endmodule

bind os_matmul_tile os_matmul_tile_chk #(.N(N), .K(K), .CW(CW)) u_chk (.*);

// File: tb/os_matmul_tile_tb.sv
module os_matmul_tile_tb;
  localparam int N  = 4;
  localparam int K  = 4;
  localparam int FL = 2*N - 1;
  localparam int CLK_PERIOD = 10;
  localparam int NT = 5;
  localparam int T_SEED [NT] = '{1, 2, 3, 4, 5};
  localparam bit T_GAP  [NT] = '{0, 0, 0, 1, 0};
  localparam bit T_ACK  [NT] = '{0, 0, 0, 0, 1};

  logic clk = 0, rst = 1, in_valid = 0, res_ack = 0;
  logic in_ready, done;
  logic [N*16-1:0] a_col = '0, b_row = '0;
  logic [N*N*32-1:0] c_flat;
  int runs = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  os_matmul_tile #(.N(N), .K(K)) u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .a_col(a_col), .b_row(b_row), .done(done), .res_ack(res_ack), .c_flat(c_flat));

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    runs++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic signed [15:0] gen(int seed, int salt, int r, int c);
    int t;
    if (seed == 1) return 16'sh7fff;
    if (seed == 2) return 16'sh8000;
    t = seed*40503 + r*9973 + c*7919 + salt*3571 + r*c*611;
    return t[15:0];
  endfunction

  task automatic run_tile(input int idx, input int seed, input bit gap, input bit stray);
    logic signed [15:0] A [N][K];
    logic signed [15:0] B [K][N];
    logic signed [31:0] E [N][N];
    logic signed [31:0] p;
    logic [N*N*32-1:0] snap;
    string tag;
    int m;
    tag = (seed <= 2) ? "R3" : gap ? "R5" : stray ? "R9" : "R2";
    if (idx > 0) tag = {tag, " R10"};
    for (int i = 0; i < N; i++)
      for (int k = 0; k < K; k++) begin
        A[i][k] = gen(seed, 1, i, k);
        B[k][i] = gen(seed, 2, k, i);
      end
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++) begin
        E[i][j] = '0;
        for (int k = 0; k < K; k++) begin
          p = 32'(A[i][k]) * 32'(B[k][j]);
          E[i][j] = E[i][j] + p;
        end
      end
    for (int k = 0; k < K; k++) begin
      if (gap && (k % 2 == 1)) begin
        @(negedge clk);
        in_valid = 0;
        a_col = '1;
        b_row = '1;
        @(posedge clk);
      end
      @(negedge clk);
      for (int i = 0; i < N; i++) begin
        a_col[i*16 +: 16] = A[i][k];
        b_row[i*16 +: 16] = B[k][i];
      end
      in_valid = 1;
      res_ack = stray && (k == 1);
      check(in_ready == 1'b1, "R4 ready during load", longint'(in_ready), 1);
      @(posedge clk);
    end
    m = 0;
    forever begin
      @(negedge clk);
      in_valid = 1;
      res_ack = 0;
      a_col = {N{16'h1357}};
      b_row = {N{16'h2468}};
      if (done || m > 100) break;
      check(in_ready == 1'b0, "R6 ready low in flush", longint'(in_ready), 0);
      m++;
    end
    check(m == FL, "R7 done latency", m, FL);
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++)
        check($signed(c_flat[(i*N+j)*32 +: 32]) == E[i][j], tag,
              longint'($signed(c_flat[(i*N+j)*32 +: 32])), longint'(E[i][j]));
    snap = c_flat;
    repeat (3) begin
      @(negedge clk);
      check(done && !in_ready, "R8 done held", longint'(done), 1);
      check(c_flat == snap, "R8 R6 result stable", longint'(c_flat[63:0]), longint'(snap[63:0]));
    end
    res_ack = 1;
    @(negedge clk);
    res_ack = 0;
    in_valid = 0;
    check(!done, "R9 done cleared", longint'(done), 0);
    check(in_ready, "R9 ready back", longint'(in_ready), 1);
    check(c_flat == '0, "R9 accumulators cleared", longint'(c_flat[63:0]), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    check(c_flat == '0, "R1 reset result", longint'(c_flat[63:0]), 0);
    check(!done, "R1 reset done", longint'(done), 0);
    check(in_ready, "R1 reset ready", longint'(in_ready), 1);

    for (int t = 0; t < NT; t++)
      run_tile(t, T_SEED[t], T_GAP[t], T_ACK[t]);

    // R1: reset in the middle of a tile
    for (int k = 0; k < 2; k++) begin
      @(negedge clk);
      a_col = {N{16'h0405}};
      b_row = {N{16'h0607}};
      in_valid = 1;
    end
    @(negedge clk);
    in_valid = 0;
    rst = 1;
    @(negedge clk);
    rst = 0;
    check(c_flat == '0, "R1 mid-tile reset result", longint'(c_flat[63:0]), 0);
    check(!done && in_ready, "R1 mid-tile reset state", longint'(in_ready), 1);
    run_tile(NT, 9, 1'b0, 1'b0);

    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end
endmodule